// File: doc/BRIEF.md
# Video Sync Conditioner with Scan Line Counter

This block prepares the raw horizontal and vertical sync inputs of a video overlay engine. Each sync input passes through a two-flop synchroniser, and a per-input control bit then corrects its polarity. On the corrected active level the block detects leading edges. The vertical leading edge is not used directly. A small state machine delays it by a programmed number of prescaler units, so that it never lands on the same instant as a horizontal edge. The prescaler counts ticks of a 4 MHz reference enable. One unit is 8 reference ticks in 2H mode and 16 reference ticks in 1H mode. The delayed vertical pulse clears a 9-bit scan line counter, and every horizontal leading edge advances that counter.

A host reads the counter as a low byte and a separate high part. Both come from one snapshot, taken when the host pulses the read strobe. The block also drives a fast-blanking output. This output is active during vertical retrace and whenever the character generator requests blanking, and its polarity is selectable. The top delay code is a freeze code. It stops the line counter, suppresses the delayed pulse and holds the RGB enable off. A palette-select bit in the control byte is passed straight to an output.

The delay state machine has four states. IDLE waits for a vertical edge. WAIT counts prescaler boundaries. FIRE lasts one cycle and emits the delayed pulse. HOLD is taken while the freeze code is programmed. The transitions are:
- IDLE→WAIT on a corrected vertical leading edge.
- WAIT→FIRE on the prescaler boundary that completes the programmed count plus one.
- FIRE→IDLE after one cycle.
- Any state→HOLD when the delay field is 4'hF.
- HOLD→IDLE when the delay field leaves 4'hF.

Top module: `ovl_sync_cond`

## Requirements
- R1: Control bit 4 inverts the horizontal sync input and bit 5 inverts the vertical sync input. A bit value of 0 means the input pulses are positive-going, and 1 means they are negative-going. Only the leading edge of the active level counts.
- R2: The internal blank condition is true when the corrected vertical sync is active, or when `blank_req` is high and `rgb_en` is high. `fblank` shows this condition inverted when control bit 6 is 1 (active low) and uninverted when it is 0 (active high). `fblank` follows a raw input change within 5 clock cycles.
- R3: In 2H mode (`mode_1h`=0), the delay from a vertical leading edge to the `vsync_dly` pulse lies between (D+1)×8 and (D+2)×8 reference ticks. D is control bits 3:0.
- R4: In 1H mode (`mode_1h`=1), the same delay lies between (D+1)×16 and (D+2)×16 reference ticks.
- R5: `vsync_dly` is a single-cycle pulse. A further vertical edge that arrives while a delay is in progress is ignored, so only one pulse results.
- R6: The scan line count goes to 0 on `vsync_dly` and increases by one on each horizontal leading edge.
- R7: The count saturates at 511 and does not wrap.
- R8: A one-cycle `line_rd` pulse captures the count. On the next cycle `line_lo` shows bits 7:0 of the captured count and `line_hi` shows bit 8. Both hold until the next `line_rd`.
- R9: While D = 4'hF, the count is frozen, no `vsync_dly` pulse occurs, `rgb_en` is 0 and `blank_req` has no effect on `fblank`.
- R10: `pal_ext` always equals control bit 7. A value of 0 selects the basic palette set and 1 selects the extended set.
- R11: After reset, `line_lo`, `line_hi`, `vsync_dly` and `fblank` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable at the 4 MHz reference rate |
| hsync_raw | input | 1 | Raw horizontal sync |
| vsync_raw | input | 1 | Raw vertical sync |
| ctrl | input | 8 | [7] palette select, [6] blank polarity, [5] vsync polarity, [4] hsync polarity, [3:0] delay code |
| mode_1h | input | 1 | 1 = 1H mode (16-tick unit), 0 = 2H mode (8-tick unit) |
| blank_req | input | 1 | Blank request from the character generator |
| line_rd | input | 1 | Snapshot strobe for the line count |
| line_lo | output | 8 | Snapshot bits 7:0 |
| line_hi | output | 1 | Snapshot bit 8 |
| vsync_dly | output | 1 | Delayed vertical sync pulse |
| rgb_en | output | 1 | RGB output enable |
| fblank | output | 1 | Fast-blanking output |
| pal_ext | output | 1 | Palette set select |

## Verification
The bench measures the delay in reference ticks for several codes in both modes. A prescaler that counts one unit too few or too many would fall outside the measured window. A vertical edge is re-triggered in the middle of a delay. A design that restarts or re-arms on that edge would shift the pulse or produce a second one. The bench drives 300 and 600 horizontal edges to check the carry into bit 8 and saturation, since a wrapping counter would read back a small value. It also drives the freeze code with horizontal and vertical activity and a blank request, to catch a counter that still moves or a blank request that still reaches the output.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;
    typedef enum logic [1:0] {
        VS_IDLE = 2'd0,
        VS_WAIT = 2'd1,
        VS_FIRE = 2'd2,
        VS_HOLD = 2'd3
    } vs_state_t;

    localparam int CTRL_W     = 8;
    localparam int DLY_W      = 4;
    localparam int HS_INV_BIT = 4;
    localparam int VS_INV_BIT = 5;
    localparam int FB_INV_BIT = 6;
    localparam int PAL_BIT    = 7;
endpackage

// File: rtl/sc_sync_edge.sv
module sc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic invert,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], raw};
            end
        end
    endgenerate

    assign level = chain[STAGES-1] ^ invert;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    assign rise = level & ~prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R1
endmodule

// File: rtl/sc_vdelay.sv
module sc_vdelay
    import sync_cond_pkg::*;
#(
    parameter int UNIT_SHORT = 8,
    parameter int UNIT_LONG  = 16,
    parameter int DW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mode_long,
    input  logic          vs_rise,
    input  logic [DW-1:0] dly,
    output logic          fire
);
    localparam int PW = (UNIT_LONG > 2) ? $clog2(UNIT_LONG) : 1;
    localparam logic [DW-1:0] FREEZE_CODE = '1;

    vs_state_t     state, nxt;
    logic [PW-1:0] presc;
    logic [PW-1:0] unit_max;
    logic          boundary;
    logic [DW:0]   units;
    logic [DW:0]   target;
    logic          frozen;

    assign frozen   = (dly == FREEZE_CODE);
    assign unit_max = mode_long ? PW'(UNIT_LONG - 1) : PW'(UNIT_SHORT - 1);
    assign boundary = tick && (presc >= unit_max);
    assign target   = (DW+1)'(dly) + (DW+1)'(1);

    // free-running prescaler of reference ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      presc <= '0;
        else if (tick)   presc <= (presc >= unit_max) ? '0 : presc + PW'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= VS_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            VS_IDLE: begin
                if (frozen)       nxt = VS_HOLD;
                else if (vs_rise) nxt = VS_WAIT;
            end
            VS_WAIT: begin
                if (frozen)                            nxt = VS_HOLD;
                else if (boundary && units >= target)  nxt = VS_FIRE;
            end
            VS_FIRE: begin
                nxt = frozen ? VS_HOLD : VS_IDLE;
            end
            VS_HOLD: begin
                if (!frozen) nxt = VS_IDLE;
            end
            default: nxt = VS_IDLE;
        endcase
    end

    // unit counter, live only while waiting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                units <= '0;
        else if (state != VS_WAIT) units <= '0;
        else if (boundary)         units <= units + (DW+1)'(1);
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        unique case (state)
            VS_FIRE: fire = 1'b1;
            default: fire = 1'b0;
        endcase
    end

    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R5
    AST_FIRE_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VS_IDLE || state == VS_HOLD) |=> !fire); // R5
    AST_NO_FIRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> !fire); // R9
    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick) && !$past(mode_long) && $stable(mode_long) |-> presc <= PW'(UNIT_SHORT - 1)); // R3
endmodule

// File: rtl/sc_line_cnt.sv
module sc_line_cnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic         freeze,
    input  logic         rd,
    output logic [W-1:0] snap
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt <= '0;
        else if (!freeze) begin
            if (clear)                    cnt <= '0;
            else if (step && cnt != CNT_MAX) cnt <= cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  snap <= '0;
        else if (rd) snap <= cnt;
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clear) |=> cnt == CNT_MAX); // R7
    AST_FREEZE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(cnt)); // R9
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !freeze) |=> cnt == '0); // R6
    AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (cnt == $past(cnt) || cnt == $past(cnt) + W'(1))); // R6
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(snap)); // R8
endmodule

// File: rtl/ovl_sync_cond.sv
module ovl_sync_cond
    import sync_cond_pkg::*;
#(
    parameter int TICKS_2H = 8,
    parameter int TICKS_1H = 16,
    parameter int LINE_W   = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              hsync_raw,
    input  logic              vsync_raw,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              mode_1h,
    input  logic              blank_req,
    input  logic              line_rd,
    output logic [7:0]        line_lo,
    output logic [LINE_W-9:0] line_hi,
    output logic              vsync_dly,
    output logic              rgb_en,
    output logic              fblank,
    output logic              pal_ext
);
    localparam logic [DLY_W-1:0] FREEZE_CODE = '1;

    logic              hs_level, hs_rise;
    logic              vs_level, vs_rise;
    logic              frozen;
    logic              fire;
    logic [LINE_W-1:0] snap;
    logic              blank_cond;
    logic              fb_q;

    assign frozen = (ctrl[DLY_W-1:0] == FREEZE_CODE);

    sc_sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
        .clk(clk), .rst_n(rst_n), .raw(hsync_raw),
        .invert(ctrl[HS_INV_BIT]), .level(hs_level), .rise(hs_rise)
    );

    sc_sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
        .clk(clk), .rst_n(rst_n), .raw(vsync_raw),
        .invert(ctrl[VS_INV_BIT]), .level(vs_level), .rise(vs_rise)
    );

    sc_vdelay #(.UNIT_SHORT(TICKS_2H), .UNIT_LONG(TICKS_1H), .DW(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .mode_long(mode_1h),
        .vs_rise(vs_rise), .dly(ctrl[DLY_W-1:0]), .fire(fire)
    );

    sc_line_cnt #(.W(LINE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(fire), .step(hs_rise),
        .freeze(frozen), .rd(line_rd), .snap(snap)
    );

    assign blank_cond = vs_level | (blank_req & ~frozen);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fb_q <= 1'b0;
        else        fb_q <= blank_cond ^ ctrl[FB_INV_BIT];
    end

    assign fblank    = fb_q;
    assign vsync_dly = fire;
    assign rgb_en    = ~frozen;
    assign pal_ext   = ctrl[PAL_BIT];
    assign line_lo   = snap[7:0];
    assign line_hi   = snap[LINE_W-1:8];

    AST_FB_RETRACE: assert property (@(posedge clk) disable iff (!rst_n)
        vs_level |=> (fblank != $past(ctrl[FB_INV_BIT]))); // R2
    AST_FB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!vs_level && (frozen || !blank_req)) |=> (fblank == $past(ctrl[FB_INV_BIT]))); // R9
    AST_RGB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_dly |-> $past(!frozen) || $past(vsync_dly) == 1'b0); // R9
endmodule

// File: tb/ovl_sync_cond_test.sv
module ovl_sync_cond_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       hsync_raw = 1'b0;
    logic       vsync_raw = 1'b0;
    logic [7:0] ctrl = 8'h00;
    logic       mode_1h = 1'b0;
    logic       blank_req = 1'b0;
    logic       line_rd = 1'b0;
    logic [7:0] line_lo;
    logic [0:0] line_hi;
    logic       vsync_dly, rgb_en, fblank, pal_ext;

    int tests = 0;
    int fails = 0;
    int div = 0;
    bit hinv = 1'b0;
    bit vinv = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        div      <= (div == 2) ? 0 : div + 1;
        ref_tick <= (div == 2);
    end

    ovl_sync_cond uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .hsync_raw(hsync_raw),
        .vsync_raw(vsync_raw), .ctrl(ctrl), .mode_1h(mode_1h), .blank_req(blank_req),
        .line_rd(line_rd), .line_lo(line_lo), .line_hi(line_hi), .vsync_dly(vsync_dly),
        .rgb_en(rgb_en), .fblank(fblank), .pal_ext(pal_ext)
    );

    // {vs_inv, fb_inv, vsync_raw, blank_req, expected fblank}
    localparam logic [4:0] FB_VEC [8] = '{
        5'b0_0_0_0_0, 5'b0_0_0_1_1, 5'b0_0_1_0_1, 5'b0_1_0_0_1,
        5'b0_1_0_1_0, 5'b1_0_1_0_0, 5'b1_0_0_0_1, 5'b1_1_0_1_0
    };

    function automatic logic [7:0] mk(bit pal, bit fbi, bit vsi, bit hsi, logic [3:0] d);
        return {pal, fbi, vsi, hsi, d};
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_ctrl(bit pal, bit fbi, bit vsi, bit hsi, logic [3:0] d);
        hinv = hsi;
        vinv = vsi;
        ctrl = mk(pal, fbi, vsi, hsi, d);
        hsync_raw = hsi;
        vsync_raw = vsi;
        cyc(8);
    endtask

    task automatic hs_pulse();
        hsync_raw = ~hinv;
        cyc(4);
        hsync_raw = hinv;
        cyc(4);
    endtask

    task automatic read_line(output int v);
        line_rd = 1'b1;
        cyc(1);
        line_rd = 1'b0;
        v = {23'd0, line_hi, line_lo};
    endtask

    // raise vertical sync, count reference ticks until the delayed pulse
    task automatic vs_measure(output int ticks, output bit seen);
        ticks = 0;
        seen  = 1'b0;
        vsync_raw = ~vinv;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (vsync_dly) begin
                seen = 1'b1;
                break;
            end
            if (ref_tick) ticks++;
        end
        cyc(4);
        vsync_raw = vinv;
        cyc(10);
    endtask

    task automatic delay_case(string req, logic [3:0] d, bit m1h);
        int t;
        bit s;
        int u;
        u = m1h ? 16 : 8;
        mode_1h = m1h;
        set_ctrl(1'b0, 1'b0, vinv, hinv, d);
        vs_measure(t, s);
        check({req, " pulse seen"}, int'(s), 1);
        check({req, " delay within window"},
              int'(t >= (int'(d) + 1) * u && t <= (int'(d) + 2) * u + 1), 1);
    endtask

    initial begin
        int v, t, pulses;
        bit s;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 line_lo after reset", int'(line_lo), 0);
        check("R11 line_hi after reset", int'(line_hi), 0);
        check("R11 vsync_dly after reset", int'(vsync_dly), 0);
        check("R11 fblank after reset", int'(fblank), 0);

        // R2 / R1 table walk
        foreach (FB_VEC[i]) begin
            vinv = FB_VEC[i][4];
            ctrl = mk(1'b0, FB_VEC[i][3], FB_VEC[i][4], 1'b0, 4'd0);
            vsync_raw = FB_VEC[i][2];
            blank_req = FB_VEC[i][1];
            cyc(5);
            check($sformatf("R2 R1 fblank vector %0d", i), int'(fblank), int'(FB_VEC[i][0]));
        end
        blank_req = 1'b0;
        vinv = 1'b0;
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        cyc(200);

        delay_case("R3 2H D=2", 4'd2, 1'b0);
        delay_case("R3 2H D=0", 4'd0, 1'b0);
        delay_case("R4 1H D=0", 4'd0, 1'b1);
        delay_case("R4 1H D=3", 4'd3, 1'b1);
        vinv = 1'b1;
        delay_case("R1 R3 inverted vsync 2H D=5", 4'd5, 1'b0);
        vinv = 1'b0;

        // R5: re-trigger during the wait gives one pulse
        mode_1h = 1'b0;
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 4'd5);
        pulses = 0;
        vsync_raw = 1'b1;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (i == 40) vsync_raw = 1'b0;
            if (i == 50) vsync_raw = 1'b1;
            if (vsync_dly) pulses++;
        end
        vsync_raw = 1'b0;
        cyc(10);
        check("R5 single delayed pulse", pulses, 1);

        // R6 with inverted hsync
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 4'd1);
        vs_measure(t, s);
        for (int i = 0; i < 7; i++) hs_pulse();
        read_line(v);
        check("R6 R1 count after 7 inverted hsyncs", v, 7);
        vs_measure(t, s);
        read_line(v);
        check("R6 count cleared by delayed vsync", v, 0);

        // R8 snapshot held
        for (int i = 0; i < 3; i++) hs_pulse();
        read_line(v);
        check("R8 snapshot 3", v, 3);
        for (int i = 0; i < 4; i++) hs_pulse();
        check("R8 snapshot held without read", int'({line_hi, line_lo}), 3);

        // R6 carry into bit 8
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 4'd1);
        vs_measure(t, s);
        for (int i = 0; i < 300; i++) hs_pulse();
        read_line(v);
        check("R8 line_lo after 300", int'(line_lo), 44);
        check("R8 line_hi after 300", int'(line_hi), 1);
        // R7 saturation
        for (int i = 0; i < 300; i++) hs_pulse();
        read_line(v);
        check("R7 saturate at 511", v, 511);

        // R9 freeze
        vs_measure(t, s);
        for (int i = 0; i < 5; i++) hs_pulse();
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 4'hF);
        check("R9 rgb_en off", int'(rgb_en), 0);
        for (int i = 0; i < 3; i++) hs_pulse();
        vs_measure(t, s);
        check("R9 no delayed pulse", int'(s), 0);
        read_line(v);
        check("R9 count frozen", v, 5);
        blank_req = 1'b1;
        cyc(5);
        check("R9 blank request ignored", int'(fblank), 0);
        blank_req = 1'b0;
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 4'd1);
        check("R9 rgb_en restored", int'(rgb_en), 1);

        // R10
        set_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 4'd1);
        check("R10 pal_ext extended", int'(pal_ext), 1);
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 4'd1);
        check("R10 pal_ext basic", int'(pal_ext), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        tests++;
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule